// File: doc/BRIEF.md
# Clock-Crossing Receive FIFO with Transit-Time Meter

This block carries received line words from a recovered line clock into a datapath clock through an asynchronous FIFO. Each FIFO word holds several line symbols side by side (two, four or eight, set by a parameter), so one write moves a group of symbols at once. Read and write pointers cross between the two domains as Gray codes through two-flop synchronisers. Full is derived on the write side and not-empty on the read side, each from the other domain's synchronised pointer.

Alongside the data path, a meter measures how many datapath (read) clock cycles one FIFO word takes to pass through. It tags one written word at a time and counts read-clock edges until that word is consumed. It then sums a window of such integer samples, with 2^WIN_LOG samples per window. At the end of each window the sum is latched as an unsigned fixed-point latency with seven integer bits. A parameter selects how the result is reported. The compact form is a 14-bit field with 7 fractional bits, sitting in the upper bits of a 32-bit timer status word. The high-resolution form is a separate integer word and a 16-bit fraction word. The result holds steady between windows, so software may read it at any time.

Top module: `cdc_transit_fifo`

## Requirements
- R1: Words written with `wr_valid` while `wr_full` is low leave `rd_data` in write order; `rd_valid` is high whenever at least one word is held, and a read happens on a read-clock edge where `rd_en` and `rd_valid` are both high.
- R2: `wr_full` is high once 2^ADDR_W words are held, and writes presented while it is high are dropped without changing the stored contents; it falls again after the reads have crossed back to the write side.
- R3: `rd_en` while `rd_valid` is low has no effect: no word is lost, and a word written later is the next one presented.
- R4: A latency sample is the number of rising read-clock edges strictly after the write edge of the tagged word, up to and including the read edge that consumes it; the smallest possible sample is 3. Only one word is tagged at a time, and the next tag is armed after the read of the previous one has been seen on the write side.
- R5: After every 2^WIN_LOG samples the result becomes the sum of those samples shifted left by (F − WIN_LOG), where F is 7 in compact mode and 16 in high-resolution mode; so with a full window the value is the mean latency in fixed point with seven integer bits.
- R6: The result is zero after reset and keeps its value between window completions.
- R7: With HIRES = 0, `timer_word[31:18]` carries the 14-bit result (integer in bits 31..25, fraction in bits 24..18), `timer_word[17:0]` is zero, and `hr_int` and `hr_frac` are zero.
- R8: With HIRES = 1, `hr_int` carries the 7-bit integer part zero-extended to 16 bits, `hr_frac` carries the 16-bit fraction, and `timer_word` is zero.
- R9: Each synchronous reset (`wrst` on the write clock, `rrst` on the read clock) clears its domain's pointers, tag state, accumulator and result; after reset `wr_full` and `rd_valid` are low.
- R10: A sample larger than 127 is counted as 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Recovered line clock (write side) |
| wrst | input | 1 | Synchronous reset, write domain |
| wr_valid | input | 1 | Write request for `wr_data` |
| wr_data | input | SYMS*SYM_W | Line word of SYMS symbols |
| wr_full | output | 1 | FIFO holds 2^ADDR_W words |
| rclk | input | 1 | Datapath clock (read side) |
| rrst | input | 1 | Synchronous reset, read domain |
| rd_en | input | 1 | Read request |
| rd_data | output | SYMS*SYM_W | Word at the head of the FIFO |
| rd_valid | output | 1 | FIFO is not empty |
| timer_word | output | 32 | Compact latency in bits 31..18 (HIRES = 0) |
| hr_int | output | 16 | Integer part of the latency (HIRES = 1) |
| hr_frac | output | 16 | Fractional part of the latency (HIRES = 1) |

## Verification
The bench builds two copies side by side from the same stimulus. The first is compact, with WIN_LOG = 7, ADDR_W = 3 and two 10-bit symbols, so real 128-sample windows complete and a depth of eight makes full reachable in a few writes. The second is high-resolution with WIN_LOG = 4, so sixteen-sample windows come round often enough to check many 16-bit fractions. The clocks run at 6 ns (write) and 4 ns (read) with edges that never coincide, which makes every sample an exact edge count that can be taken at the ports. The read-enable delays vary, and one sample runs past 127 cycles to reach saturation.

// File: rtl/cdc_transit_fifo.sv
module cdc_transit_fifo #(
  parameter int SYMS    = 2,
  parameter int SYM_W   = 10,
  parameter int ADDR_W  = 4,
  parameter bit HIRES   = 1'b0,
  parameter int WIN_LOG = 7
) (
  input  logic                    wclk,
  input  logic                    wrst,
  input  logic                    wr_valid,
  input  logic [SYMS*SYM_W-1:0]   wr_data,
  output logic                    wr_full,
  input  logic                    rclk,
  input  logic                    rrst,
  input  logic                    rd_en,
  output logic [SYMS*SYM_W-1:0]   rd_data,
  output logic                    rd_valid,
  output logic [31:0]             timer_word,
  output logic [15:0]             hr_int,
  output logic [15:0]             hr_frac
);
  localparam int DW     = SYMS * SYM_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PW     = ADDR_W + 1;
  localparam int INT_W  = 7;
  localparam int FRAC_W = HIRES ? 16 : 7;
  localparam int RES_W  = INT_W + FRAC_W;
  localparam int SUM_W  = INT_W + WIN_LOG;
  localparam int SH     = FRAC_W - WIN_LOG;
  localparam logic [INT_W-1:0] SAT = '1;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  // write domain
  logic [PW-1:0] wbin, wgray, rg1, rg2, mark_ptr;
  logic          mark_t, armed, ak1, ak2, ak3;
  logic [PW-1:0] rgray;
  logic          done_t;

  wire           wfire = wr_valid & ~wr_full;
  wire [PW-1:0]  wnext = wbin + 1'b1;

  assign wr_full = (wgray == {~rg2[PW-1:PW-2], rg2[PW-3:0]});

  always_ff @(posedge wclk)
    if (wfire) mem[wbin[ADDR_W-1:0]] <= wr_data;

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wbin <= '0; wgray <= '0; rg1 <= '0; rg2 <= '0; mark_ptr <= '0;
      mark_t <= 1'b0; armed <= 1'b1; ak1 <= 1'b0; ak2 <= 1'b0; ak3 <= 1'b0;
    end else begin
      rg1 <= rgray; rg2 <= rg1;
      ak1 <= done_t; ak2 <= ak1; ak3 <= ak2;
      if (wfire) begin
        wbin  <= wnext;
        wgray <= wnext ^ (wnext >> 1);
      end
      if (wfire && armed) begin
        mark_t   <= ~mark_t;
        mark_ptr <= wbin;
        armed    <= 1'b0;
      end else if (ak2 ^ ak3) begin
        armed <= 1'b1;
      end
    end
  end

  // read domain
  logic [PW-1:0]      rbin, wg1, wg2;
  logic               mk1, mk2, mk3, active;
  logic [INT_W-1:0]   cnt, cur;
  logic [SUM_W-1:0]   sum;
  logic [WIN_LOG-1:0] nsamp;
  logic [RES_W-1:0]   res;

  wire               det   = mk2 ^ mk3;
  wire               rfire = rd_en & rd_valid;
  wire               hit   = rfire & (det | active) & (rbin == mark_ptr);
  wire [SUM_W-1:0]   sum_n = sum + SUM_W'(cur);
  wire [PW-1:0]      rnext = rbin + 1'b1;

  assign rd_valid = (rgray != wg2);
  assign rd_data  = mem[rbin[ADDR_W-1:0]];
  assign cur      = det ? INT_W'(3) : ((cnt == SAT) ? SAT : cnt + 1'b1);

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rbin <= '0; rgray <= '0; wg1 <= '0; wg2 <= '0;
      mk1 <= 1'b0; mk2 <= 1'b0; mk3 <= 1'b0; active <= 1'b0; done_t <= 1'b0;
      cnt <= '0; sum <= '0; nsamp <= '0; res <= '0;
    end else begin
      wg1 <= wgray; wg2 <= wg1;
      mk1 <= mark_t; mk2 <= mk1; mk3 <= mk2;
      if (rfire) begin
        rbin  <= rnext;
        rgray <= rnext ^ (rnext >> 1);
      end
      if (det) cnt <= INT_W'(3);
      else if (active && cnt != SAT) cnt <= cnt + 1'b1;
      if (hit) begin
        active <= 1'b0;
        done_t <= ~done_t;
        nsamp  <= nsamp + 1'b1;
        if (&nsamp) begin
          res <= RES_W'(sum_n) << SH;
          sum <= '0;
        end else begin
          sum <= sum_n;
        end
      end else if (det) begin
        active <= 1'b1;
      end
    end
  end

  generate
    if (HIRES) begin : g_hires
      assign timer_word = '0;
      assign hr_int     = 16'(res[RES_W-1:FRAC_W]);
      assign hr_frac    = res[FRAC_W-1:0];
    end else begin : g_compact
      assign timer_word = {res, 18'd0};
      assign hr_int     = '0;
      assign hr_frac    = '0;
    end
  endgenerate

  always @(posedge wclk)
    if (!wrst) AST_NO_OVERFLOW: assert ((wbin - g2b(rg2)) <= PW'(DEPTH)); // R2

  AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (rrst)
    (g2b(wg2) - rbin) <= PW'(DEPTH)); // R3

  AST_GRAY_STEP: assert property (@(posedge wclk) disable iff (wrst)
    1'b1 |=> $countones(wgray ^ $past(wgray)) <= 1); // R1

  AST_SAMPLE_FLOOR: assert property (@(posedge rclk) disable iff (rrst)
    hit |-> cur >= INT_W'(3)); // R4

  AST_RESULT_HOLD: assert property (@(posedge rclk) disable iff (rrst)
    !hit |=> $stable(res)); // R6
endmodule

// File: tb/cdc_transit_fifo_tb.sv
module cdc_transit_fifo_tb;
  localparam int SYMS = 2, SYM_W = 10, DW = SYMS * SYM_W, AW = 3, DEPTH = 1 << AW;
  localparam int NS = 256;

  logic wclk, rclk, wrst, rrst, wr_valid, rd_en;
  logic [DW-1:0] wr_data, rd_data, rd_data_h;
  logic wr_full, wr_full_h, rd_valid, rd_valid_h;
  logic [31:0] timer_word, timer_word_h;
  logic [15:0] hr_int, hr_frac, hr_int_h, hr_frac_h;

  cdc_transit_fifo #(.SYMS(SYMS), .SYM_W(SYM_W), .ADDR_W(AW), .HIRES(1'b0), .WIN_LOG(7)) u_dut (
    .wclk(wclk), .wrst(wrst), .wr_valid(wr_valid), .wr_data(wr_data), .wr_full(wr_full),
    .rclk(rclk), .rrst(rrst), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .timer_word(timer_word), .hr_int(hr_int), .hr_frac(hr_frac));

  cdc_transit_fifo #(.SYMS(SYMS), .SYM_W(SYM_W), .ADDR_W(AW), .HIRES(1'b1), .WIN_LOG(4)) u_hr (
    .wclk(wclk), .wrst(wrst), .wr_valid(wr_valid), .wr_data(wr_data), .wr_full(wr_full_h),
    .rclk(rclk), .rrst(rrst), .rd_en(rd_en), .rd_data(rd_data_h), .rd_valid(rd_valid_h),
    .timer_word(timer_word_h), .hr_int(hr_int_h), .hr_frac(hr_frac_h));

  initial begin rclk = 0; forever #2 rclk = ~rclk; end
  initial begin wclk = 0; #1 wclk = 1; forever #3 wclk = ~wclk; end

  int errs = 0, checks = 0, redge = 0, wr_edge = 0, lat = 0;
  bit got = 0;
  logic [DW-1:0] dq[$];
  longint sum_c = 0, n_c = 0, exp_c = 0, sum_h = 0, n_h = 0, exp_h = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge rclk) redge <= redge + 1;

  // monitor: a read happens at the next rising edge
  always @(negedge rclk) begin
    if (rd_en && rd_valid) begin
      if (dq.size() == 0) chk(1'b0, "R1 unexpected word", longint'(rd_data), -1);
      else begin
        logic [DW-1:0] e;
        e = dq.pop_front();
        chk(rd_data == e, "R1 data order", longint'(rd_data), longint'(e));
        chk(rd_data_h == e, "R1 data order (hires copy)", longint'(rd_data_h), longint'(e));
      end
      lat = redge + 1 - wr_edge;
      got = 1;
    end
  end

  task automatic push_word(input logic [DW-1:0] d);
    @(negedge wclk);
    wr_valid = 1; wr_data = d;
    @(posedge wclk);
    wr_edge = redge;
    dq.push_back(d);
    @(negedge wclk);
    wr_valid = 0;
  endtask

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    wrst = 1; rrst = 1; wr_valid = 0; rd_en = 0; wr_data = '0;
    repeat (6) @(negedge wclk);
    wrst = 0; rrst = 0;
    repeat (4) @(negedge wclk);
    // R9 reset state
    chk(wr_full == 0, "R9 full after reset", wr_full, 0);
    chk(rd_valid == 0, "R9 valid after reset", rd_valid, 0);
    chk(timer_word == 0, "R9 timer after reset", timer_word, 0);
    chk(hr_int_h == 0 && hr_frac_h == 0, "R9 hires after reset", {hr_int_h, hr_frac_h}, 0);

    for (int i = 0; i < NS; i++) begin
      int d;
      longint s;
      d = (i * 7) % 11;
      if (i == 100) d = 140;
      got = 0;
      if (d == 0) begin @(negedge rclk); rd_en = 1; end
      push_word(DW'(i * 37 + 5));
      if (d != 0) begin
        repeat (d) @(negedge rclk);
        rd_en = 1;
      end
      wait (got);
      @(negedge rclk);
      rd_en = 0;
      repeat (8) @(negedge wclk);
      if (d == 0) chk(lat == 3, "R4 minimum sample", lat, 3);
      s = (lat > 127) ? 127 : lat;
      if (i == 100) chk(lat > 127, "R10 long sample", lat, 128);
      sum_c += s; n_c++;
      if (n_c == 128) begin exp_c = sum_c; sum_c = 0; n_c = 0; end
      sum_h += s; n_h++;
      if (n_h == 16) begin exp_h = sum_h << 12; sum_h = 0; n_h = 0; end
      // R5 window value, R6 hold between windows, R7 field placement
      chk(timer_word == 32'(exp_c << 18), (n_c == 0) ? "R5 compact window" : "R6 compact hold",
          timer_word, exp_c << 18);
      chk(hr_int == 0 && hr_frac == 0, "R7 hires outputs idle in compact", {hr_int, hr_frac}, 0);
      chk({hr_int_h, hr_frac_h} == 32'(exp_h), (n_h == 0) ? "R8 hires window" : "R6 hires hold",
          {hr_int_h, hr_frac_h}, exp_h);
      chk(timer_word_h == 0, "R8 timer idle in hires", timer_word_h, 0);
    end
    // both windows ended with the saturated sample in the first one (R10)
    chk(exp_c != 0, "R5 compact window reached", exp_c, 1);

    // fill past capacity with reads held off
    @(negedge wclk);
    wr_valid = 1;
    for (int k = 0; k < DEPTH + 2; k++) begin
      wr_data = DW'(1000 + k);
      if (k < DEPTH) dq.push_back(wr_data);
      @(negedge wclk);
    end
    wr_valid = 0;
    chk(wr_full == 1, "R2 full at capacity", wr_full, 1);
    repeat (5) @(negedge wclk);
    chk(rd_valid == 1, "R1 valid while holding", rd_valid, 1);
    @(negedge rclk);
    rd_en = 1;
    repeat (DEPTH + 6) @(negedge rclk);
    chk(dq.size() == 0, "R2 dropped writes not stored", dq.size(), 0);
    chk(rd_valid == 0, "R3 empty after drain", rd_valid, 0);
    rd_en = 0;
    repeat (6) @(negedge wclk);
    chk(wr_full == 0, "R2 full released", wr_full, 0);
    // R3: reads while empty must not have moved the read side
    @(negedge wclk);
    wr_valid = 1; wr_data = DW'(777);
    @(negedge wclk);
    wr_valid = 0;
    repeat (6) @(negedge rclk);
    chk(rd_valid == 1, "R3 valid after late write", rd_valid, 1);
    chk(rd_data == DW'(777), "R3 next word after empty reads", rd_data, 777);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule